// File: doc/BRIEF.md
# Single-Digit Decimal Multiplier

This block multiplies two decimal digits, each held in 4-bit BCD, and returns the product as two packed BCD digits. The tens digit is in bits 7:4 and the units digit is in bits 3:0. It has no clock and no state, so the product follows the current operands.

The sixteen one-bit partial products `x[i] & y[j]` each carry a binary weight of 2^(i+j). Each weight is spread over decimal positions before any addition takes place: units positions 1, 2, 4 and 8, and tens positions 10, 20 and 40. In a legal digit, bit 3 never appears together with bit 2 or bit 1. Partial products that can never be high at the same time are therefore OR-merged into a single bit of one row, which leaves four decimal rows.

A chain of three two-digit decimal adders sums the four rows. Each adder applies the usual add-six fix to any digit whose binary sum passes nine. The first two rows can hold a units digit of 10 to 15, so the first adder normalises both of its operands before it adds them. An operand above nine raises an error flag and clears the product.

Top module: `bcdm_digit_mul`

## Requirements
- R1: For operands 0 to 9, `prod_bcd[7:4]` equals (a*b)/10 and `prod_bcd[3:0]` equals (a*b)%10.
- R2: For legal operands, each nibble of `prod_bcd` is a legal decimal digit (0 to 9).
- R3: `bad_input` is 1 exactly when `a_dig` or `b_dig` holds a code from 10 to 15, and 0 otherwise.
- R4: While `bad_input` is 1, `prod_bcd` is 8'h00, whatever the other operand holds.
- R5: Swapping the two operands leaves `prod_bcd` unchanged.
- R6: A zero operand gives 8'h00. An operand of one gives the other digit in the units nibble and 0 in the tens nibble.
- R7: The outputs depend only on the present inputs. They settle after an input change without any clock edge, and no earlier operand pair affects them.
- R8: Fixed cases: 0x0=8'h00, 1x5=8'h05, 4x5=8'h20, 3x7=8'h21, 2x8=8'h16, 6x6=8'h36, 9x8=8'h72, 9x9=8'h81.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dig | input | 4 | First operand, one BCD digit |
| b_dig | input | 4 | Second operand, one BCD digit |
| prod_bcd | output | 8 | Product as packed BCD, tens digit in bits 7:4 |
| bad_input | output | 1 | High when either operand is not a decimal digit |

## Verification
The bench builds the block with its default parameters: 4-bit digits, a two-digit product and four partial-product rows. With these values the whole operand space has only 256 pairs, so every legal pair is checked against an arithmetic reference and every illegal code is tried on each side against all sixteen values of the other operand. That reaches every input pattern that can make a units digit of 10 to 15 inside the first adder, so the merging of exclusive terms and the operand pre-correction are both covered by the exhaustive sweep.

// File: rtl/bcdm_pkg.sv
package bcdm_pkg;
  localparam int DIGIT_W     = 4;
  localparam int PROD_DIGITS = 2;
  localparam int PROD_W      = DIGIT_W * PROD_DIGITS;
  localparam int ROWS        = 4;
  localparam logic [DIGIT_W-1:0] MAX_DIGIT = 4'd9;
  localparam logic [DIGIT_W-1:0] DEC_FIX   = 4'd6;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [PROD_W-1:0]  bcd2_t;
endpackage

// File: rtl/bcdm_pp_rows.sv
// Partial products, weights spread onto decimal positions, exclusive terms
// OR-merged so that four rows remain.
module bcdm_pp_rows
  import bcdm_pkg::*;
(
  input  digit_t                         x,
  input  digit_t                         y,
  output logic [ROWS-1:0][PROD_W-1:0]    rows
);
  logic [DIGIT_W-1:0][DIGIT_W-1:0] pp;

  for (genvar i = 0; i < DIGIT_W; i++) begin : g_px
    for (genvar j = 0; j < DIGIT_W; j++) begin : g_py
      assign pp[i][j] = x[i] & y[j];
    end
  end

  // weight 16 = 10 + 4 + 2 ; the three terms are pairwise exclusive
  logic w16;
  // weight 32 = 20 + 8 + 4 ; exclusive pair
  logic w32;
  // weight 64 = 40 + 20 + 4
  logic w64;
  // weight 8 groups, each group pairwise exclusive; the 8 of w32 is split
  logic w8_a, w8_b;

  assign w16  = pp[3][1] | pp[2][2] | pp[1][3];
  assign w32  = pp[3][2] | pp[2][3];
  assign w64  = pp[3][3];
  assign w8_a = pp[0][3] | pp[2][1] | pp[3][2];
  assign w8_b = pp[3][0] | pp[1][2] | pp[2][3];

  // bit order per row: {t8, t4, t2, t1, u8, u4, u2, u1}
  assign rows[0] = {1'b0, w64, w32 | w64, w16, w8_a, pp[2][0] | w64, pp[1][0], pp[0][0]};
  assign rows[1] = {4'b0000, w8_b, pp[1][1] | w32, pp[0][1], 1'b0};
  assign rows[2] = {4'b0000, 1'b0, pp[0][2], w16, 1'b0};
  assign rows[3] = {4'b0000, 1'b0, w16, 2'b00};
endmodule

// File: rtl/bcdm_digit_add.sv
// One decimal digit: binary add, then +6 when the sum passes nine.
module bcdm_digit_add
  import bcdm_pkg::*;
(
  input  digit_t a,
  input  digit_t b,
  input  logic   ci,
  output digit_t s,
  output logic   co
);
  logic [DIGIT_W:0] raw;

  assign raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, ci};
  assign co  = raw[DIGIT_W] | (raw[3] & (raw[2] | raw[1]));
  assign s   = raw[DIGIT_W-1:0] + (co ? DEC_FIX : '0);
endmodule

// File: rtl/bcdm_bcd_add.sv
// Multi-digit decimal adder; optional normalisation of operand digits above nine.
module bcdm_bcd_add
  import bcdm_pkg::*;
#(
  parameter int NDIG       = PROD_DIGITS,
  parameter bit PRECORRECT = 1'b0,
  localparam int W         = NDIG * DIGIT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0]  a_n, b_n;
  logic [NDIG:0] ca, cb, cs;

  if (PRECORRECT) begin : g_pre
    assign ca[0] = 1'b0;
    assign cb[0] = 1'b0;
    for (genvar d = 0; d < NDIG; d++) begin : g_dig
      bcdm_digit_add u_na (.a(a[d*DIGIT_W +: DIGIT_W]), .b('0), .ci(ca[d]),
                           .s(a_n[d*DIGIT_W +: DIGIT_W]), .co(ca[d+1]));
      bcdm_digit_add u_nb (.a(b[d*DIGIT_W +: DIGIT_W]), .b('0), .ci(cb[d]),
                           .s(b_n[d*DIGIT_W +: DIGIT_W]), .co(cb[d+1]));
    end
  end else begin : g_nopre
    assign a_n = a;
    assign b_n = b;
    assign ca  = '0;
    assign cb  = '0;
  end

  assign cs[0] = 1'b0;
  for (genvar d = 0; d < NDIG; d++) begin : g_sum
    bcdm_digit_add u_add (.a(a_n[d*DIGIT_W +: DIGIT_W]), .b(b_n[d*DIGIT_W +: DIGIT_W]),
                          .ci(cs[d]), .s(s[d*DIGIT_W +: DIGIT_W]), .co(cs[d+1]));
  end

  assign co = cs[NDIG] | ca[NDIG] | cb[NDIG];
endmodule

// File: rtl/bcdm_digit_mul.sv
module bcdm_digit_mul
  import bcdm_pkg::*;
(
  input  logic [3:0] a_dig,
  input  logic [3:0] b_dig,
  output logic [7:0] prod_bcd,
  output logic       bad_input
);
  logic [ROWS-1:0][PROD_W-1:0] rows;
  logic [ROWS-1:0][PROD_W-1:0] acc;
  logic [ROWS-1:1]             stage_co;

  assign bad_input = (a_dig > MAX_DIGIT) | (b_dig > MAX_DIGIT);

  bcdm_pp_rows u_rows (.x(a_dig), .y(b_dig), .rows(rows));

  assign acc[0] = rows[0];
  for (genvar k = 1; k < ROWS; k++) begin : g_chain
    bcdm_bcd_add #(.NDIG(PROD_DIGITS), .PRECORRECT(k == 1)) u_add (
      .a (acc[k-1]),
      .b (rows[k]),
      .s (acc[k]),
      .co(stage_co[k])
    );
  end

  assign prod_bcd = bad_input ? '0 : acc[ROWS-1];
endmodule

// File: rtl/bcdm_digit_mul_chk.sv
module bcdm_digit_mul_chk
  import bcdm_pkg::*;
(
  input logic [3:0]      a_dig,
  input logic [3:0]      b_dig,
  input logic [7:0]      prod_bcd,
  input logic            bad_input,
  input logic [ROWS-1:1] stage_co
);
  always_comb begin
    if (!bad_input) begin
      a_r1_value: assert (int'(prod_bcd[7:4]) * 10 + int'(prod_bcd[3:0]) == int'(a_dig) * int'(b_dig))
        else $error("R1 value mismatch");
      a_r1_no_stage_carry: assert (stage_co == '0)
        else $error("R1 adder stage overflow");
      a_r2_digits_legal: assert (prod_bcd[7:4] <= MAX_DIGIT && prod_bcd[3:0] <= MAX_DIGIT)
        else $error("R2 illegal digit");
    end
    if (a_dig > MAX_DIGIT || b_dig > MAX_DIGIT) begin
      a_r3_flag_raised: assert (bad_input) else $error("R3 flag missing");
    end else begin
      a_r3_flag_clear: assert (!bad_input) else $error("R3 flag spurious");
    end
    if (bad_input) begin
      a_r4_zero_on_bad: assert (prod_bcd == 8'h00) else $error("R4 product not cleared");
    end
    if (!bad_input && (a_dig == 4'd0 || b_dig == 4'd0)) begin
      a_r6_zero_operand: assert (prod_bcd == 8'h00) else $error("R6 zero operand");
    end
  end
endmodule

bind bcdm_digit_mul bcdm_digit_mul_chk u_chk (
  .a_dig    (a_dig),
  .b_dig    (b_dig),
  .prod_bcd (prod_bcd),
  .bad_input(bad_input),
  .stage_co (stage_co)
);

// File: tb/tb_bcdm_digit_mul.sv
module tb_bcdm_digit_mul;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 8;
  // {a, b, expected product}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0000, 16'h1505, 16'h4520, 16'h3721,
    16'h9981, 16'h9872, 16'h2816, 16'h6636
  };

  logic       clk = 1'b0;
  logic [3:0] a_dig = 4'd0;
  logic [3:0] b_dig = 4'd0;
  logic [7:0] prod_bcd;
  logic       bad_input;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [7:0] seen [10][10];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcdm_digit_mul dut (.a_dig(a_dig), .b_dig(b_dig), .prod_bcd(prod_bcd), .bad_input(bad_input));

  function automatic logic [7:0] ref_prod(input int a, input int b);
    int p = a * b;
    return {4'(p / 10), 4'(p % 10)};
  endfunction

  task automatic compare(input string req, input logic [7:0] exp_p, input logic exp_bad);
    n_checks++;
    if (prod_bcd !== exp_p || bad_input !== exp_bad) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual prod=%h bad=%b expected prod=%h bad=%b",
               req, a_dig, b_dig, prod_bcd, bad_input, exp_p, exp_bad);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    a_dig = a;
    b_dig = b;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    // idle operands: zero times zero, flag low
    #(CLK_PERIOD/4);
    compare("R6 idle", 8'h00, 1'b0);

    // R8 table of fixed cases
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][15:12], VEC[v][11:8]);
      compare("R8", VEC[v][7:0], 1'b0);
    end

    // R1 / R2 exhaustive over legal digits
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        apply(4'(a), 4'(b));
        seen[a][b] = prod_bcd;
        compare("R1", ref_prod(a, b), 1'b0);
        n_checks++;
        if (prod_bcd[7:4] > 4'd9 || prod_bcd[3:0] > 4'd9) begin
          n_fail++;
          $display("FAIL R2 a=%0d b=%0d actual prod=%h expected digits <= 9", a, b, prod_bcd);
        end
      end
    end

    // R5 operand swap
    for (int a = 0; a < 10; a++) begin
      for (int b = a + 1; b < 10; b++) begin
        n_checks++;
        if (seen[a][b] !== seen[b][a]) begin
          n_fail++;
          $display("FAIL R5 a=%0d b=%0d actual=%h expected=%h", a, b, seen[a][b], seen[b][a]);
        end
      end
    end

    // R6 zero and one operands
    for (int d = 0; d < 10; d++) begin
      apply(4'd0, 4'(d));
      compare("R6 zero", 8'h00, 1'b0);
      apply(4'(d), 4'd1);
      compare("R6 one", {4'd0, 4'(d)}, 1'b0);
    end

    // R3 / R4 illegal codes on either side against every other value
    for (int bad = 10; bad < 16; bad++) begin
      for (int o = 0; o < 16; o++) begin
        apply(4'(bad), 4'(o));
        compare("R3/R4 a illegal", 8'h00, 1'b1);
        apply(4'(o), 4'(bad));
        compare("R3/R4 b illegal", 8'h00, 1'b1);
      end
    end

    // R7 settles with no clock edge and keeps no history
    @(posedge clk);
    #1;
    a_dig = 4'd15; b_dig = 4'd15;
    #1;
    compare("R7 illegal", 8'h00, 1'b1);
    a_dig = 4'd9; b_dig = 4'd7;
    #1;
    compare("R7 after illegal", 8'h63, 1'b0);
    a_dig = 4'd8; b_dig = 4'd8;
    #1;
    compare("R7 change", 8'h64, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule